// File: doc/BRIEF.md
# Pipelined Polar/Cartesian CORDIC Converter

This block moves a signal between Cartesian and polar form inside a digital phase-control loop. In vectoring mode it takes a signed in-phase/quadrature pair and returns its phase and its magnitude. In rotation mode it takes an amplitude and a phase and returns the matching in-phase/quadrature pair. The same shift-add datapath serves both directions. A mode bit travels with every sample, so the two directions can be mixed freely from one cycle to the next.

Twelve micro-rotations are folded into six register stages, with two micro-rotations in each stage. The block accepts a new sample on every clock and produces its result exactly six clocks later.

Phase is an unsigned fraction of a full turn, so wrap-around is ordinary modular arithmetic. Before the first micro-rotation, a half-turn pre-rotation brings any input into the half-plane where the iterations converge. The CORDIC gain is removed by multiplying the inputs by a constant of about 0.6073 before the first micro-rotation.

Top module: `cordic_polar_pp`

## Requirements
- R1: Phase encoding: `in_phase` and `out_phase` are unsigned 16-bit fractions of a turn. Code 0 is the +I axis, angles grow counter-clockwise, and 65536 codes make one turn. In vectoring mode, `out_phase` is within 0.1 degree (18 codes, measured modulo a turn) of atan2(`in_y`, `in_x`).
- R2: In vectoring mode, `out_x` carries sqrt(`in_x`² + `in_y`²) within 3 LSB plus 0.1 %, and is never negative.
- R3: Vectoring is correct in all four quadrants, including a negative `in_x`. A half-turn pre-rotation leaves a non-negative x value ahead of the first micro-rotation.
- R4: In rotation mode, with amplitude A on `in_x` and phase P on `in_phase`, `out_x` = A·cos P and `out_y` = A·sin P, each within 4 LSB plus 0.1 % of |A|. This holds over the whole turn, including codes just below 65536. After the pre-rotation, the residual angle lies within a quarter turn.
- R5: `out_valid` equals `in_valid` delayed by exactly 6 clock cycles, and each accepted sample yields exactly one result.
- R6: Mode selection: `in_mode` 0 selects vectoring and 1 selects rotation, sampled with each sample. A new sample can be accepted every cycle, including back-to-back samples of alternating mode, and each result follows its own sample's mode. Parameter `MODE_SEL` = 1 or 2 fixes the mode to vectoring or rotation.
- R7: While `rst_n` is low, and until a valid sample has passed through the pipeline, `out_valid` is low.
- R8: Full-scale inputs do not overflow. An input of (-32768, 0) gives a magnitude of 32768, and (-32768, -32768) gives 46341 on the 17-bit output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Input sample qualifier |
| in_mode | input | 1 | 0 = vectoring, 1 = rotation (used when `MODE_SEL` = 0) |
| in_x | input | 16 | Signed I (vectoring) or amplitude (rotation) |
| in_y | input | 16 | Signed Q (vectoring); ignored in rotation |
| in_phase | input | 16 | Phase in turn fractions (rotation); ignored in vectoring |
| out_valid | output | 1 | Result qualifier, six cycles after `in_valid` |
| out_x | output | 17 | Signed magnitude (vectoring) or I (rotation) |
| out_y | output | 17 | Signed near-zero residual (vectoring) or Q (rotation) |
| out_phase | output | 16 | Phase (vectoring) or near-zero residual angle (rotation) |

## Verification
The assertions assume that `in_valid` and `in_mode` are driven to known levels from the first clock edge. They also assume that reset is held long enough to clear the six valid flags. The pre-rotation properties further assume that the signed amplitude and the I/Q inputs are full 16-bit two's-complement values, so that the scaled and negated copy always fits the internal width. The bench drives every input from time zero, holds reset for several cycles, and keeps rotation amplitudes non-negative. It also uses vectoring inputs large enough, at least 1000 LSB, that the phase is well defined.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  typedef enum logic {
    CM_VEC = 1'b0,
    CM_ROT = 1'b1
  } cmode_e;

  // reciprocal of the CORDIC gain, unsigned Q0.16
  localparam int unsigned KINV_Q16 = 39797;
  localparam int          MAX_ITER = 16;

  // atan(2^-i) as a 32-bit fraction of a full turn
  function automatic logic [31:0] atan_turn32(input int i);
    case (i)
      0:       return 32'h2000_0000;
      1:       return 32'h12E4_051E;
      2:       return 32'h09FB_385B;
      3:       return 32'h0511_11D4;
      4:       return 32'h028B_0D43;
      5:       return 32'h0145_D7E1;
      6:       return 32'h00A2_F61E;
      7:       return 32'h0051_7C55;
      8:       return 32'h0028_BE53;
      9:       return 32'h0014_5F2F;
      10:      return 32'h000A_2F98;
      11:      return 32'h0005_17CC;
      12:      return 32'h0002_8BE6;
      13:      return 32'h0001_45F3;
      14:      return 32'h0000_A2F9;
      15:      return 32'h0000_517D;
      default: return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/cordic_prerot.sv
// Gain pre-compensation and half-turn pre-rotation (combinational).
module cordic_prerot
  import cordic_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int G  = 3,
  parameter int XW = DW + G + 3,
  parameter int ZW = AW + 2
) (
  input  logic                 rot,
  input  logic signed [DW-1:0] x_in,
  input  logic signed [DW-1:0] y_in,
  input  logic        [AW-1:0] phase_in,
  output logic signed [XW-1:0] x0,
  output logic signed [XW-1:0] y0,
  output logic        [ZW-1:0] z0
);

  localparam int PW = DW + 18;
  localparam logic [ZW-1:0] HALF = ZW'(1) << (ZW - 1);

  // v * (1/K), kept with G fractional guard bits
  function automatic logic signed [XW-1:0] scale(input logic signed [DW-1:0] v);
    logic signed [PW-1:0] a, k, p;
    a = {{(PW-DW){v[DW-1]}}, v};
    k = PW'(KINV_Q16);
    p = a * k;
    return XW'(p >>> (16 - G));
  endfunction

  logic signed [XW-1:0] xs, ys;
  logic        [ZW-1:0] zf;

  always_comb begin
    xs = scale(x_in);
    ys = scale(y_in);
    zf = {phase_in, {(ZW-AW){1'b0}}};
    if (rot == CM_ROT) begin
      y0 = '0;
      if (zf[ZW-1] ^ zf[ZW-2]) begin
        x0 = -xs;
        z0 = zf - HALF;
      end else begin
        x0 = xs;
        z0 = zf;
      end
    end else begin
      if (xs[XW-1]) begin
        x0 = -xs;
        y0 = -ys;
        z0 = HALF;
      end else begin
        x0 = xs;
        y0 = ys;
        z0 = '0;
      end
    end
  end

endmodule

// File: rtl/cordic_stage2.sv
// One pipeline stage: two micro-rotations followed by a register.
module cordic_stage2
  import cordic_pkg::*;
#(
  parameter int XW    = 22,
  parameter int ZW    = 18,
  parameter int FIRST = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_v,
  input  logic                 in_rot,
  input  logic signed [XW-1:0] in_x,
  input  logic signed [XW-1:0] in_y,
  input  logic        [ZW-1:0] in_z,
  output logic                 out_v,
  output logic                 out_rot,
  output logic signed [XW-1:0] out_x,
  output logic signed [XW-1:0] out_y,
  output logic        [ZW-1:0] out_z
);

  localparam int PW = 2 * XW + ZW;

  function automatic logic [ZW-1:0] atan_at(input int i);
    logic [31:0] r;
    r = atan_turn32(i) + (32'd1 << (31 - ZW));
    return r[31 -: ZW];
  endfunction

  // d=1 turns the vector counter-clockwise and lowers the angle accumulator
  function automatic logic [PW-1:0] micro(input logic signed [XW-1:0] x,
                                          input logic signed [XW-1:0] y,
                                          input logic        [ZW-1:0] z,
                                          input logic                 rot,
                                          input int                   i);
    logic                 d;
    logic signed [XW-1:0] xs, ys;
    logic        [ZW-1:0] a;
    d  = (rot == CM_ROT) ? ~z[ZW-1] : y[XW-1];
    xs = x >>> i;
    ys = y >>> i;
    a  = atan_at(i);
    if (d) return {x - ys, y + xs, z - a};
    else   return {x + ys, y - xs, z + a};
  endfunction

  logic [PW-1:0] m0, m1;

  always_comb begin
    m0 = micro(in_x, in_y, in_z, in_rot, FIRST);
    m1 = micro(m0[PW-1 -: XW], m0[ZW+XW-1 -: XW], m0[ZW-1:0], in_rot, FIRST + 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_v <= 1'b0;
    else        out_v <= in_v;
  end

  always_ff @(posedge clk) begin
    out_rot <= in_rot;
    out_x   <= m1[PW-1 -: XW];
    out_y   <= m1[ZW+XW-1 -: XW];
    out_z   <= m1[ZW-1:0];
  end

endmodule

// File: rtl/cordic_polar_pp.sv
// Top: pre-rotation, ITER/2 two-iteration stages, output rounding.
module cordic_polar_pp
  import cordic_pkg::*;
#(
  parameter int DW       = 16,
  parameter int AW       = 16,
  parameter int ITER     = 12,
  parameter int G        = 3,
  parameter int MODE_SEL = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_mode,
  input  logic [DW-1:0]     in_x,
  input  logic [DW-1:0]     in_y,
  input  logic [AW-1:0]     in_phase,
  output logic              out_valid,
  output logic [DW:0]       out_x,
  output logic [DW:0]       out_y,
  output logic [AW-1:0]     out_phase
);

  localparam int NST = ITER / 2;
  localparam int XW  = DW + G + 3;
  localparam int ZW  = AW + 2;
  localparam int OW  = DW + 1;

  function automatic logic [OW-1:0] round_xy(input logic signed [XW-1:0] v);
    logic signed [XW-1:0] t;
    t = v + XW'(1 << (G - 1));
    return OW'(t >>> G);
  endfunction

  function automatic logic [AW-1:0] round_z(input logic [ZW-1:0] z);
    logic [ZW-1:0] t;
    t = z + ZW'(1 << (ZW - AW - 1));
    return t[ZW-1 -: AW];
  endfunction

  logic mode_rot;

  if (MODE_SEL == 0) begin : g_mode_port
    assign mode_rot = in_mode;
  end else begin : g_mode_fixed
    assign mode_rot = (MODE_SEL == 2);
  end

  logic signed [XW-1:0] sx [0:NST];
  logic signed [XW-1:0] sy [0:NST];
  logic        [ZW-1:0] sz [0:NST];
  logic                 sm [0:NST];
  logic                 sv [0:NST];

  assign sv[0] = in_valid;
  assign sm[0] = mode_rot;

  cordic_prerot #(.DW(DW), .AW(AW), .G(G), .XW(XW), .ZW(ZW)) u_pre (
    .rot      (mode_rot),
    .x_in     (in_x),
    .y_in     (in_y),
    .phase_in (in_phase),
    .x0       (sx[0]),
    .y0       (sy[0]),
    .z0       (sz[0])
  );

  for (genvar s = 0; s < NST; s++) begin : g_st
    cordic_stage2 #(.XW(XW), .ZW(ZW), .FIRST(2 * s)) u_st (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_v    (sv[s]),
      .in_rot  (sm[s]),
      .in_x    (sx[s]),
      .in_y    (sy[s]),
      .in_z    (sz[s]),
      .out_v   (sv[s+1]),
      .out_rot (sm[s+1]),
      .out_x   (sx[s+1]),
      .out_y   (sy[s+1]),
      .out_z   (sz[s+1])
    );
  end

  // named internal events for the checker
  logic signed [XW-1:0] pre_x;
  logic        [ZW-1:0] pre_z;
  logic                 tail_rot;
  assign pre_x    = sx[0];
  assign pre_z    = sz[0];
  assign tail_rot = sm[NST];

  assign out_valid = sv[NST];
  assign out_x     = round_xy(sx[NST]);
  assign out_y     = round_xy(sy[NST]);
  assign out_phase = round_z(sz[NST]);

endmodule

// File: rtl/cordic_polar_pp_chk.sv
module cordic_polar_pp_chk #(
  parameter int NST = 6,
  parameter int XW  = 22,
  parameter int ZW  = 18,
  parameter int OW  = 17
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_rot,
  input logic signed [XW-1:0] pre_x,
  input logic        [ZW-1:0] pre_z,
  input logic                 out_valid,
  input logic                 tail_rot,
  input logic        [OW-1:0] out_x
);

  logic [NST-1:0] vdly;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vdly <= '0;
    else        vdly <= {vdly[NST-2:0], in_valid};
  end

  // R5: output qualifier trails the input qualifier by NST cycles
  a_r5_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vdly[NST-1]);

  // R3: vectoring pre-rotation leaves x in the right half-plane
  a_r3_prerot_right_half: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_rot) |-> !pre_x[XW-1]);

  // R4: rotation pre-rotation leaves the angle within a quarter turn
  a_r4_prerot_quarter: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_rot) |-> (pre_z[ZW-1] == pre_z[ZW-2]));

  // R2: vectoring magnitude is never negative
  a_r2_mag_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !tail_rot) |-> !out_x[OW-1]);

  // R7: reset empties the output qualifier
  a_r7_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

endmodule

bind cordic_polar_pp cordic_polar_pp_chk #(
  .NST(NST), .XW(XW), .ZW(ZW), .OW(OW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_rot    (mode_rot),
  .pre_x     (pre_x),
  .pre_z     (pre_z),
  .out_valid (out_valid),
  .tail_rot  (tail_rot),
  .out_x     (out_x)
);

// File: tb/cordic_polar_pp_tb.sv
module cordic_polar_pp_tb;

  localparam int  CLK_PERIOD = 40;
  localparam int  LAT        = 6;
  localparam real TWO_PI     = 6.283185307179586;
  localparam real TURN       = 65536.0;
  localparam real PH_TOL     = 0.1 / 360.0 * TURN;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_mode = 1'b0;
  logic [15:0] in_x = '0;
  logic [15:0] in_y = '0;
  logic [15:0] in_phase = '0;
  logic        out_valid;
  logic [16:0] out_x;
  logic [16:0] out_y;
  logic [15:0] out_phase;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cordic_polar_pp u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_mode   (in_mode),
    .in_x      (in_x),
    .in_y      (in_y),
    .in_phase  (in_phase),
    .out_valid (out_valid),
    .out_x     (out_x),
    .out_y     (out_y),
    .out_phase (out_phase)
  );

  typedef struct {
    bit    rot;
    real   ex;
    real   ey;
    real   eph;
    real   amp;
    int    tcyc;
    string req;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc   = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0f expected %0f", req, what, act, expv);
    end
  endtask

  function automatic real absr(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  task automatic drive_vec(input int x, input int y, input string req);
    exp_t e;
    real  rx, ry, a;
    @(negedge clk);
    in_valid = 1'b1;
    in_mode  = 1'b0;
    in_x     = 16'(x);
    in_y     = 16'(y);
    in_phase = 16'h5A5A;
    rx = real'(x);
    ry = real'(y);
    a  = $atan2(ry, rx) / TWO_PI * TURN;
    if (a < 0.0) a = a + TURN;
    e.rot = 1'b0; e.ex = $sqrt(rx * rx + ry * ry); e.ey = 0.0;
    e.eph = a; e.amp = e.ex; e.tcyc = cyc; e.req = req;
    sb.push_back(e);
  endtask

  task automatic drive_rot(input int amp, input int ph, input string req);
    exp_t e;
    real  th;
    @(negedge clk);
    in_valid = 1'b1;
    in_mode  = 1'b1;
    in_x     = 16'(amp);
    in_y     = 16'h7FFF;
    in_phase = 16'(ph);
    th = real'(ph) / TURN * TWO_PI;
    e.rot = 1'b1; e.ex = real'(amp) * $cos(th); e.ey = real'(amp) * $sin(th);
    e.eph = 0.0; e.amp = real'(amp); e.tcyc = cyc; e.req = req;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R5", "unexpected out_valid", 1.0, 0.0);
      end else begin
        exp_t e;
        real  ax, ay, d, tol;
        e  = sb.pop_front();
        ax = real'($signed(out_x));
        ay = real'($signed(out_y));
        check((cyc - e.tcyc) == LAT, "R5", "latency", real'(cyc - e.tcyc), real'(LAT));
        if (!e.rot) begin
          tol = 3.0 + 0.001 * e.ex;
          check(absr(ax - e.ex) <= tol && !out_x[16], {e.req, "/R2"}, "magnitude", ax, e.ex);
          d = real'(out_phase) - e.eph;
          if (d > TURN / 2.0)  d = d - TURN;
          if (d < -TURN / 2.0) d = d + TURN;
          check(absr(d) <= PH_TOL, {e.req, "/R1"}, "phase", real'(out_phase), e.eph);
        end else begin
          tol = 4.0 + 0.001 * absr(e.amp);
          check(absr(ax - e.ex) <= tol, {e.req, "/R4"}, "I", ax, e.ex);
          check(absr(ay - e.ey) <= tol, {e.req, "/R4"}, "Q", ay, e.ey);
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL R5 watchdog: actual %0d expected %0d", cyc, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R7: qualifier low in reset, even with in_valid high
    repeat (2) @(negedge clk);
    in_valid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R7", "out_valid in reset", real'(out_valid), 0.0);
    end
    in_valid = 1'b0;
    rst_n    = 1'b1;
    repeat (8) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R7", "out_valid idle after reset", real'(out_valid), 0.0);
    end

    // R1: axis points and ordinary angles
    drive_vec(20000, 0, "R1");
    drive_vec(0, 20000, "R1");
    drive_vec(12000, 9000, "R1");
    drive_vec(30000, -25000, "R1");
    drive_vec(1000, -1, "R1_wrap");
    idle(3);
    // R3: left half-plane
    drive_vec(-20000, 0, "R3");
    drive_vec(0, -20000, "R3");
    drive_vec(-15000, 7000, "R3");
    drive_vec(-9000, -21000, "R3");
    idle(2);
    // R8: full scale
    drive_vec(-32768, 0, "R8");
    drive_vec(-32768, -32768, "R8");
    drive_vec(32767, 32767, "R8");
    idle(4);
    // R4: rotation across the turn
    drive_rot(20000, 0, "R4");
    drive_rot(20000, 16384, "R4");
    drive_rot(20000, 32768, "R4");
    drive_rot(20000, 49152, "R4");
    drive_rot(20000, 65535, "R4_wrap");
    drive_rot(20000, 10000, "R4");
    drive_rot(25000, 40000, "R4");
    drive_rot(32767, 8192, "R8");
    idle(5);
    // R6: alternating modes back to back
    for (int k = 0; k < 8; k++) begin
      if (k % 2 == 0) drive_vec(5000 + 1000 * k, 3000 - 1500 * k, "R6");
      else            drive_rot(15000, 7000 * k, "R6");
    end
    idle(LAT + 6);
    check(sb.size() == 0, "R5", "results outstanding", real'(sb.size()), 0.0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule